// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Unit

This block decides, once per instruction boundary of a small 8-bit controller core, whether a pending interrupt request is taken and which one. It combines each request flag with its own enable bit, a global enable and a per-source priority bit. Within the current in-service situation it picks a winner and, after a short acknowledge window, emits a one-cycle acknowledge. That acknowledge carries the 16-bit vector address and a request to push the program counter. The core then performs the forced long call. The status word is not saved by this call, and software must preserve it.

During the acknowledge window a newly arrived high-priority request can still displace a low-priority candidate. The core then never runs a single instruction of the displaced handler. A request that arrives after the window waits for the next instruction boundary. On acknowledge, the block also produces a one-hot clear mask. The mask names the winning flag only when hardware is meant to clear that flag: the timer overflows always, and the two external inputs only when they are set to transition mode. Every other flag, such as the serial flags, is left for software.

The controller has three states. ST_RUN waits for an instruction boundary. ST_WIN is the acknowledge window. ST_CALL is the one-cycle acknowledge. The transitions are:
- take: ST_RUN to ST_WIN, on a boundary with an eligible request.
- replace: ST_WIN to ST_WIN, when a high request displaces a low candidate while the window is still counting.
- close: ST_WIN to ST_CALL, when the window count reaches zero.
- issue: ST_CALL to ST_RUN, which also sets the in-service level.

Top module: `irq_ack_unit`

## Requirements
- R1: After reset, ack_o and push_pc_o are 0, clr_o and vec_o are all zero, and no level is in service.
- R2: The vector of source index i is 0x0003 + 8*i for i < 14, and 0x0083 + 8*(i-14) for i >= 14 (source 13 maps to 0x006B, source 14 to 0x0083, source 18 to 0x00A3).
- R3: A source with prio_hi_i bit set (high level) beats any low-level source. Within one level, the lowest source index wins.
- R4: A decision is taken only when boundary_i is 1 at a clock edge. ack_o then rises WIN_CYC edges after that edge, stays high for exactly one cycle, and push_pc_o equals ack_o.
- R5: With glob_en_i = 0, or with a source's en_i bit = 0, a boundary produces no acknowledge for that source, and the request flags are not cleared.
- R6: clr_o is zero outside ack_o, and is one-hot or zero during ack_o. Sources 1 and 3 (timers) are always cleared. Source 0 is cleared only if ext_edge_i[0] = 1, and source 2 only if ext_edge_i[1] = 1. No other source is ever cleared.
- R7: While in the window, an eligible high-level request present at any window edge (including the last) replaces a low-level candidate, and the acknowledge carries the high-level vector.
- R8: A request that first appears in the acknowledge cycle or later does not change that acknowledge. It is taken at a later boundary.
- R9: With low level in service, only high-level requests are taken. With high level in service, no request is taken.
- R10: A reti_i pulse clears the high in-service level if it is set, and otherwise the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NSRC | Pending request flags, one per source |
| en_i | input | NSRC | Per-source enable bits |
| glob_en_i | input | 1 | Global interrupt enable |
| prio_hi_i | input | NSRC | Priority bit per source, 1 = high level |
| ext_edge_i | input | 2 | Trigger mode of external inputs 0 and 1, 1 = transition |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| reti_i | input | 1 | Return-from-interrupt strobe from the core |
| ack_o | output | 1 | One-cycle acknowledge strobe |
| push_pc_o | output | 1 | Request to push the program counter |
| vec_o | output | 16 | Vector address, valid with ack_o |
| clr_o | output | NSRC | One-hot hardware clear mask, valid with ack_o |

## Verification
The bench builds the unit with its defaults: 19 sources, a two-edge window and the table gap after index 13. This lets a single sweep reach both the last slot before the gap and the final slot at 0x00A3. The two-edge window leaves a cycle inside the window where a late high request can still win. It also leaves a distinct acknowledge cycle where a newly raised request must be ignored. Two priority levels with independent in-service bits make nesting, blocking at equal level and the order of clearing on return all observable through later acknowledges.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WIN  = 2'd1,
        ST_CALL = 2'd2
    } ack_state_e;

    // Slot address: fixed stride with one forward jump past a gap index.
    function automatic logic [15:0] slot_addr(input int idx, input int base,
                                              input int step, input int gap_idx,
                                              input int gap_bytes);
        int a;
        a = base + step * idx;
        if (idx >= gap_idx) a = a + gap_bytes;
        return 16'(a);
    endfunction

endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int N  = 19,
    parameter int IW = 5
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
    parameter int N  = 19,
    parameter int IW = 5
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  prio_hi_i,
    output logic          hi_any_o,
    output logic [IW-1:0] hi_idx_o,
    output logic          lo_any_o,
    output logic [IW-1:0] lo_idx_o
);
    logic [N-1:0] hi_vec;
    logic [N-1:0] lo_vec;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_split
            assign hi_vec[g] = pend_i[g] &  prio_hi_i[g];
            assign lo_vec[g] = pend_i[g] & ~prio_hi_i[g];
        end
    endgenerate

    irq_first_set #(.N(N), .IW(IW)) i_hi (
        .vec_i (hi_vec),
        .any_o (hi_any_o),
        .idx_o (hi_idx_o)
    );

    irq_first_set #(.N(N), .IW(IW)) i_lo (
        .vec_i (lo_vec),
        .any_o (lo_any_o),
        .idx_o (lo_idx_o)
    );
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice (
    input  logic clk,
    input  logic rst_n,
    input  logic set_hi_i,
    input  logic set_lo_i,
    input  logic reti_i,
    output logic ins_hi_o,
    output logic ins_lo_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ins_hi_o <= 1'b0;
            ins_lo_o <= 1'b0;
        end else begin
            if (reti_i) begin
                if (ins_hi_o) ins_hi_o <= 1'b0;
                else          ins_lo_o <= 1'b0;
            end
            if (set_hi_i) ins_hi_o <= 1'b1;
            if (set_lo_i) ins_lo_o <= 1'b1;
        end
    end

    AST_SET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_hi_i && set_lo_i)); // R9
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_ack_pkg::*;
#(
    parameter int              NSRC      = 19,
    parameter int              WIN_CYC   = 2,
    parameter int              VEC_BASE  = 3,
    parameter int              VEC_STEP  = 8,
    parameter int              GAP_IDX   = 14,
    parameter int              GAP_BYTES = 16,
    parameter int              EXT0_IDX  = 0,
    parameter int              EXT1_IDX  = 2,
    parameter logic [NSRC-1:0] AUTO_CLR  = NSRC'(10)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            glob_en_i,
    input  logic [NSRC-1:0] prio_hi_i,
    input  logic [1:0]      ext_edge_i,
    input  logic            boundary_i,
    input  logic            reti_i,
    output logic            ack_o,
    output logic            push_pc_o,
    output logic [15:0]     vec_o,
    output logic [NSRC-1:0] clr_o
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

    ack_state_e    state;
    logic [CW-1:0] win_cnt;
    logic [IW-1:0] cand_idx;
    logic          cand_hi;

    logic [NSRC-1:0] pend;
    logic            hi_any, lo_any;
    logic [IW-1:0]   hi_idx, lo_idx;
    logic            ins_hi, ins_lo;
    logic            take_hi, take_lo;
    logic            hw_clears;
    logic [NSRC-1:0] cand_onehot;

    assign pend = req_i & en_i & {NSRC{glob_en_i}};

    irq_level_arb #(.N(NSRC), .IW(IW)) i_arb (
        .pend_i    (pend),
        .prio_hi_i (prio_hi_i),
        .hi_any_o  (hi_any),
        .hi_idx_o  (hi_idx),
        .lo_any_o  (lo_any),
        .lo_idx_o  (lo_idx)
    );

    irq_inservice i_ins (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_hi_i (ack_o &  cand_hi),
        .set_lo_i (ack_o & ~cand_hi),
        .reti_i   (reti_i),
        .ins_hi_o (ins_hi),
        .ins_lo_o (ins_lo)
    );

    assign take_hi = hi_any & ~ins_hi;
    assign take_lo = lo_any & ~ins_hi & ~ins_lo;

    // State register and candidate tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            win_cnt  <= '0;
            cand_idx <= '0;
            cand_hi  <= 1'b0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (boundary_i && (take_hi || take_lo)) begin
                        state    <= ST_WIN;
                        win_cnt  <= CW'(WIN_CYC - 1);
                        cand_hi  <= take_hi;
                        cand_idx <= take_hi ? hi_idx : lo_idx;
                    end
                end
                ST_WIN: begin
                    if (take_hi && !cand_hi) begin
                        cand_hi  <= 1'b1;
                        cand_idx <= hi_idx;
                    end
                    if (win_cnt == '0) state <= ST_CALL;
                    else               win_cnt <= win_cnt - 1'b1;
                end
                ST_CALL: state <= ST_RUN;
                default: state <= ST_RUN;
            endcase
        end
    end

    // Output decode
    always_comb begin
        cand_onehot = NSRC'(1) << cand_idx;
        hw_clears   = AUTO_CLR[cand_idx]
                    | ((int'(cand_idx) == EXT0_IDX) & ext_edge_i[0])
                    | ((int'(cand_idx) == EXT1_IDX) & ext_edge_i[1]);
        ack_o     = 1'b0;
        push_pc_o = 1'b0;
        vec_o     = '0;
        clr_o     = '0;
        unique case (state)
            ST_CALL: begin
                ack_o     = 1'b1;
                push_pc_o = 1'b1;
                vec_o     = slot_addr(int'(cand_idx), VEC_BASE, VEC_STEP,
                                      GAP_IDX, GAP_BYTES);
                clr_o     = hw_clears ? cand_onehot : '0;
            end
            default: ;
        endcase
    end

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o); // R4
    AST_PUSH_TRACKS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_pc_o) |-> ack_o); // R4
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o)); // R6
    AST_CLR_ONLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> (clr_o == '0)); // R6
    AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (vec_o[2:0] == 3'(VEC_BASE))); // R2
    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !glob_en_i) |=> (state != ST_WIN)); // R5
    AST_HI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && ins_hi) |=> (state != ST_WIN)); // R9
    AST_NO_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIN && cand_hi) |=> cand_hi); // R7
    AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !boundary_i) |=> (state == ST_RUN)); // R4
endmodule

// File: tb/test_irq_ack_unit.sv
module test_irq_ack_unit;
    localparam int N   = 19;
    localparam int WIN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  en = '1;
    logic          gen = 1'b1;
    logic [N-1:0]  prio = '0;
    logic [1:0]    edge_m = 2'b11;
    logic          bnd = 1'b0;
    logic          reti = 1'b0;
    logic          ack, push;
    logic [15:0]   vec;
    logic [N-1:0]  clr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int acks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0]  vec;
        logic [N-1:0] clr;
        int           at_edge;
        string        tag;
    } exp_t;
    exp_t q[$];

    irq_ack_unit #(.NSRC(N), .WIN_CYC(WIN)) i_irq_ack_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .glob_en_i(gen),
        .prio_hi_i(prio), .ext_edge_i(edge_m), .boundary_i(bnd),
        .reti_i(reti), .ack_o(ack), .push_pc_o(push), .vec_o(vec),
        .clr_o(clr)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] exp_vec(input int i);
        return (i < 14) ? 16'(3 + 8 * i) : 16'(16'h83 + 8 * (i - 14));
    endfunction

    function automatic logic [N-1:0] exp_clr(input int i, input logic [1:0] m);
        logic hit;
        hit = (i == 1) || (i == 3) || (i == 0 && m[0]) || (i == 2 && m[1]);
        return hit ? (N'(1) << i) : '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each acknowledge with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && ack && !done) begin
            acks++;
            if (q.size() == 0) begin
                chk("R4 unexpected ack vec", 32'(vec), 32'hFFFF);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " vec"},  32'(vec),  32'(e.vec));
                chk({e.tag, " clr"},  32'(clr),  32'(e.clr));
                chk({e.tag, " R4 push"}, 32'(push), 32'd1);
                chk({e.tag, " R4 timing"}, 32'(cyc), 32'(e.at_edge));
            end
        end
    end

    task automatic expect_src(input int i, input logic [N-1:0] c, input string tag);
        exp_t e;
        e.vec = exp_vec(i);
        e.clr = c;
        e.at_edge = cyc + 1 + WIN;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic pulse_bnd();
        bnd = 1'b1;
        @(negedge clk);
        bnd = 1'b0;
    endtask

    task automatic settle();
        repeat (WIN + 3) @(negedge clk);
    endtask

    task automatic fire(input int i, input logic [N-1:0] c, input string tag);
        @(negedge clk);
        expect_src(i, c, tag);
        pulse_bnd();
        settle();
    endtask

    task automatic no_ack(input string tag);
        int n0;
        n0 = acks;
        @(negedge clk);
        pulse_bnd();
        settle();
        chk(tag, 32'(acks), 32'(n0));
    endtask

    task automatic do_reti();
        @(negedge clk);
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ack", 32'(ack), 0);
        chk("R1 push", 32'(push), 0);
        chk("R1 vec", 32'(vec), 0);
        chk("R1 clr", 32'(clr), 0);

        // R3 simultaneous low requests: lowest index wins, timer flag cleared (R6)
        req = (N'(1) << 4) | (N'(1) << 1);
        fire(1, exp_clr(1, edge_m), "R3 simultaneous low");
        req = '0;
        do_reti();

        // R3 high level beats lower index at low level
        req = (N'(1) << 0) | (N'(1) << 5);
        prio = N'(1) << 5;
        fire(5, '0, "R3 high over low");
        req = '0; prio = '0;
        do_reti();

        // R2 sweep of all slots, R6 clearing with transition mode on
        for (int i = 0; i < N; i++) begin
            req = N'(1) << i;
            fire(i, exp_clr(i, 2'b11), "R2 R6 sweep");
            req = '0;
            do_reti();
        end

        // R6 level mode: external flags not cleared
        edge_m = 2'b00;
        req = N'(1) << 0;
        fire(0, '0, "R6 level ext0");
        req = '0; do_reti();
        req = N'(1) << 2;
        fire(2, '0, "R6 level ext1");
        req = '0; do_reti();
        edge_m = 2'b11;

        // R5 global enable off, then source enable off
        gen = 1'b0;
        req = N'(1) << 3;
        no_ack("R5 global off");
        chk("R5 clr untouched", 32'(clr), 0);
        gen = 1'b1;
        en = ~(N'(1) << 3);
        no_ack("R5 source off");
        en = '1; req = '0;

        // R7 preemption inside the window
        req = N'(1) << 7;
        @(negedge clk);
        expect_src(10, '0, "R7 window preempt");
        pulse_bnd();
        req[10] = 1'b1; prio = N'(1) << 10;
        settle();
        req = '0; prio = '0;
        do_reti();

        // R7 preemption at the last window edge
        req = N'(1) << 7;
        @(negedge clk);
        expect_src(11, '0, "R7 last window edge");
        pulse_bnd();
        @(negedge clk);
        req[11] = 1'b1; prio = N'(1) << 11;
        settle();
        req = '0; prio = '0;
        do_reti();

        // R8 request arriving in the acknowledge cycle
        req = N'(1) << 7;
        @(negedge clk);
        expect_src(7, '0, "R8 late request");
        pulse_bnd();
        @(negedge clk);
        @(negedge clk);
        req[10] = 1'b1; prio = N'(1) << 10;
        settle();
        // R9 nesting: high taken while low in service
        fire(10, '0, "R9 R8 nested high");
        // R9 high in service blocks all
        no_ack("R9 high blocks");
        req[10] = 1'b0;
        // R10 first return clears high only
        do_reti();
        no_ack("R10 R9 low still in service");
        do_reti();
        fire(7, '0, "R10 low cleared");
        req = '0; prio = '0;
        do_reti();

        repeat (4) @(negedge clk);
        chk("R4 scoreboard drained", 32'(q.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule